// File: doc/BRIEF.md
# Serial DAC Write Sequencer

This block is the host-side controller for a four-channel, 12-bit serial-input DAC. User logic in the system clock domain pulses a start request together with a 2-bit channel number and a 12-bit code. The sequencer then produces a complete write on the converter's serial pins: an active-low chip select, a serial clock, serial data, and an active-low load strobe. The strobe moves the shifted code into the selected channel's output register.

The block can also issue a hardware reset of the converter. The user picks the reset code through a select level: low gives code 000h and high gives code 800h. The sequencer sets that level first and then pulses the active-low reset pin.

Every minimum interface time is a parameter counted in system clock cycles, rounded up by whoever sets the parameter. The sequencer holds each pin phase for exactly the derived number of cycles. A busy level covers the whole operation, and a one-cycle done pulse marks its end.

Top module: `dac_write_seq`

## Requirements
- R1: A write sends 16 bits MSB first, with exactly one rising edge of the serial clock per bit. The word is channel[1:0] in bits 15:14, zeros in bits 13:12, and the code in bits 11:0.
- R2: Each serial clock low phase lasts max(T_CLKL, T_SETUP) cycles and each high phase lasts max(T_CLKH, T_HOLD) cycles. Serial data changes only while the clock is low.
- R3: Chip select falls together with the first clock low phase, max(T_CLKL, T_SETUP, T_CSS, T_LD1) cycles before the first rising edge.
- R4: Chip select rises only while the clock is high, max(T_CLKH, T_HOLD, T_CSH, T_LD2) cycles after the last rising edge. The clock is never low while chip select is high.
- R5: The load strobe falls at the same edge as chip select rises and stays low for T_LDW cycles. No clock rising edge occurs while it is low.
- R6: After reset, and whenever the block is not busy, chip select, clock, load strobe and DAC reset are all high, and done is low.
- R7: Busy rises at the cycle a request is accepted and falls at the edge where the load strobe (or DAC reset) returns high. Done is high for exactly that one cycle.
- R8: Start requests made while busy are ignored. The channel and code are taken only in the accepting cycle, and later input changes do not alter the word sent.
- R9: A reset request latches the reset-select output from rst_mid_i (0 selects code 000h, 1 selects code 800h). The select is held T_RSS cycles before the DAC reset falls, and the DAC reset stays low T_RSTW cycles. Chip select and the load strobe stay high throughout.
- R10: When a reset request and a start arrive in the same idle cycle, the reset is performed and the start is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Write request, one cycle |
| chan_i | input | 2 | Target channel |
| code_i | input | 12 | Code to write |
| rst_req_i | input | 1 | DAC reset request, one cycle |
| rst_mid_i | input | 1 | Reset code choice: 0 = 000h, 1 = 800h |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle end-of-operation pulse |
| cs_n_o | output | 1 | Chip select, active low |
| sclk_o | output | 1 | Serial clock, idle high |
| sdi_o | output | 1 | Serial data |
| load_n_o | output | 1 | Load strobe, active low |
| dac_rst_n_o | output | 1 | DAC reset, active low |
| rst_sel_o | output | 1 | Reset code select level |

## Verification
The assertions assume that start_i, rst_req_i and their data inputs are synchronous to clk, and that every timing parameter is at least one. Under those conditions, the edge orderings on the serial pins follow only from the state sequence.

The bench changes inputs on the falling clock edge and gives each request as a single-cycle pulse. It scrambles the channel and code right after acceptance, and it issues some starts on purpose while a write is in progress. The pin timing is measured from the outputs in cycles and compared with values derived from the default parameters.

// File: rtl/dws_pkg.sv
`timescale 1ns/1ps
package dws_pkg;
    localparam int WORD_W = 16;
    localparam int CODE_W = 12;
    localparam int CHAN_W = 2;

    typedef enum logic [2:0] {
        ST_IDLE, ST_LOW, ST_HIGH, ST_TAIL, ST_LOAD, ST_RSEL, ST_RLOW
    } dws_state_e;

    typedef struct packed {
        logic cs_n;
        logic sclk;
        logic load_n;
        logic rst_n;
    } dws_pins_t;

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic [WORD_W-1:0] build_word(logic [CHAN_W-1:0] ch,
                                                     logic [CODE_W-1:0] code);
        return {ch, 2'b00, code};
    endfunction

    function automatic dws_pins_t pins_of(dws_state_e s);
        dws_pins_t p;
        p = '{cs_n: 1'b1, sclk: 1'b1, load_n: 1'b1, rst_n: 1'b1};
        case (s)
            ST_LOW:  begin p.cs_n = 1'b0; p.sclk = 1'b0; end
            ST_HIGH: p.cs_n = 1'b0;
            ST_TAIL: p.cs_n = 1'b0;
            ST_LOAD: p.load_n = 1'b0;
            ST_RLOW: p.rst_n = 1'b0;
            default: ;
        endcase
        return p;
    endfunction
endpackage

// File: rtl/dws_timer.sv
`timescale 1ns/1ps
module dws_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] value_i,
    output logic         expired_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                 cnt_q <= '0;
        else if (load_i)         cnt_q <= value_i - 1'b1;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/dws_shifter.sv
`timescale 1ns/1ps
module dws_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              shift_i,
    output logic              bit_o,
    output logic              last_o
);
    localparam int CW = $clog2(WORD_W);

    logic [WORD_W-1:0] sh_q;
    logic [CW-1:0]     idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q  <= '0;
            idx_q <= '0;
        end else if (load_i) begin
            sh_q  <= word_i;
            idx_q <= '0;
        end else if (shift_i) begin
            sh_q  <= {sh_q[WORD_W-2:0], 1'b0};
            idx_q <= idx_q + 1'b1;
        end
    end

    assign bit_o  = sh_q[WORD_W-1];
    assign last_o = (idx_q == CW'(WORD_W-1));
endmodule

// File: rtl/dac_write_seq.sv
`timescale 1ns/1ps
module dac_write_seq
    import dws_pkg::*;
#(
    parameter int T_SETUP = 4,
    parameter int T_HOLD  = 3,
    parameter int T_CLKH  = 4,
    parameter int T_CLKL  = 7,
    parameter int T_CSS   = 7,
    parameter int T_CSH   = 2,
    parameter int T_LD1   = 5,
    parameter int T_LD2   = 2,
    parameter int T_LDW   = 6,
    parameter int T_RSS   = 4,
    parameter int T_RSTW  = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [CHAN_W-1:0] chan_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              rst_req_i,
    input  logic              rst_mid_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              cs_n_o,
    output logic              sclk_o,
    output logic              sdi_o,
    output logic              load_n_o,
    output logic              dac_rst_n_o,
    output logic              rst_sel_o
);
    localparam int LOW_N   = max2(T_CLKL, T_SETUP);
    localparam int FIRST_N = max2(LOW_N, max2(T_CSS, T_LD1));
    localparam int HIGH_N  = max2(T_CLKH, T_HOLD);
    localparam int TAIL_N  = max2(HIGH_N, max2(T_CSH, T_LD2));
    localparam int T_MAX   = max2(max2(FIRST_N, TAIL_N),
                                  max2(max2(T_LDW, T_RSS), T_RSTW));
    localparam int TW      = $clog2(T_MAX + 1);

    dws_state_e  state_q, state_d;
    dws_pins_t   pins_q;
    logic        done_q, done_d;
    logic        rsel_q;
    logic        t_load, t_exp;
    logic [TW-1:0] t_val;
    logic        sh_load, sh_shift, sh_bit, sh_last;

    dws_timer #(.W(TW)) u_timer (
        .clk(clk), .rst(rst), .load_i(t_load), .value_i(t_val), .expired_o(t_exp)
    );

    dws_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk(clk), .rst(rst), .load_i(sh_load), .word_i(build_word(chan_i, code_i)),
        .shift_i(sh_shift), .bit_o(sh_bit), .last_o(sh_last)
    );

    always_comb begin
        state_d  = state_q;
        t_load   = 1'b0;
        t_val    = '0;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        done_d   = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (rst_req_i) begin
                    state_d = ST_RSEL; t_load = 1'b1; t_val = TW'(T_RSS);
                end else if (start_i) begin
                    state_d = ST_LOW; t_load = 1'b1; t_val = TW'(FIRST_N);
                    sh_load = 1'b1;
                end
            end
            ST_LOW: if (t_exp) begin
                t_load = 1'b1;
                if (sh_last) begin state_d = ST_TAIL; t_val = TW'(TAIL_N); end
                else         begin state_d = ST_HIGH; t_val = TW'(HIGH_N); end
            end
            ST_HIGH: if (t_exp) begin
                state_d = ST_LOW; t_load = 1'b1; t_val = TW'(LOW_N); sh_shift = 1'b1;
            end
            ST_TAIL: if (t_exp) begin
                state_d = ST_LOAD; t_load = 1'b1; t_val = TW'(T_LDW);
            end
            ST_LOAD: if (t_exp) begin state_d = ST_IDLE; done_d = 1'b1; end
            ST_RSEL: if (t_exp) begin
                state_d = ST_RLOW; t_load = 1'b1; t_val = TW'(T_RSTW);
            end
            ST_RLOW: if (t_exp) begin state_d = ST_IDLE; done_d = 1'b1; end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            pins_q  <= pins_of(ST_IDLE);
            done_q  <= 1'b0;
            rsel_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            pins_q  <= pins_of(state_d);
            done_q  <= done_d;
            if (state_q == ST_IDLE && rst_req_i) rsel_q <= rst_mid_i;
        end
    end

    assign busy_o      = (state_q != ST_IDLE);
    assign done_o      = done_q;
    assign cs_n_o      = pins_q.cs_n;
    assign sclk_o      = pins_q.sclk;
    assign sdi_o       = sh_bit;
    assign load_n_o    = pins_q.load_n;
    assign dac_rst_n_o = pins_q.rst_n;
    assign rst_sel_o   = rsel_q;

    AST_SDI_STEADY_HIGH: assert property (@(posedge clk) disable iff (rst)
        (sclk_o && $past(sclk_o) && !cs_n_o) |-> $stable(sdi_o)); // R2
    AST_CS_RISE_CLK_HIGH: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n_o) |-> sclk_o); // R4
    AST_CLK_LOW_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        !sclk_o |-> !cs_n_o); // R4
    AST_NO_EDGE_IN_LOAD: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk_o) |-> load_n_o); // R5
    AST_LOAD_CS_HIGH: assert property (@(posedge clk) disable iff (rst)
        !load_n_o |-> cs_n_o); // R5
    AST_IDLE_LEVELS: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (cs_n_o && sclk_o && load_n_o && dac_rst_n_o)); // R6
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!busy_o && $past(busy_o))); // R7
    AST_RSEL_HELD: assert property (@(posedge clk) disable iff (rst)
        !dac_rst_n_o |-> ($stable(rst_sel_o) && cs_n_o && load_n_o)); // R9
endmodule

// File: tb/dac_write_seq_tb.sv
`timescale 1ns/1ps
module dac_write_seq_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0, rst_req_i = 1'b0, rst_mid_i = 1'b0;
    logic [1:0]  chan_i = '0;
    logic [11:0] code_i = '0;
    logic busy_o, done_o, cs_n_o, sclk_o, sdi_o, load_n_o, dac_rst_n_o, rst_sel_o;

    // expected phase lengths from the default parameters
    localparam int E_FIRST = 7, E_LOW = 7, E_HIGH = 4, E_TAIL = 4;
    localparam int E_LDW = 6, E_RSS = 4, E_RSTW = 9;
    localparam int E_BUSY = E_FIRST + 15*E_HIGH + 15*E_LOW + E_TAIL + E_LDW;

    always #4 clk = ~clk;

    dac_write_seq u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .chan_i(chan_i), .code_i(code_i),
        .rst_req_i(rst_req_i), .rst_mid_i(rst_mid_i), .busy_o(busy_o), .done_o(done_o),
        .cs_n_o(cs_n_o), .sclk_o(sclk_o), .sdi_o(sdi_o), .load_n_o(load_n_o),
        .dac_rst_n_o(dac_rst_n_o), .rst_sel_o(rst_sel_o)
    );

    int n_run = 0, n_fail = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // port-level monitor, sampled on the falling edge
    int cyc = 0, t_busy = 0, t_csf = 0, t_lrise = 0, t_sfall = 0, t_lf = 0, t_rf = 0;
    int busy_cyc, done_cnt, cs_falls, rises, first_gap, lo_min, lo_max, hi_min, hi_max;
    int sdi_bad, csh, cs_bad, ld2, ldw, load_rises, rss, rstw;
    logic [15:0] word;
    logic p_busy = 0, p_cs = 1, p_sclk = 1, p_sdi = 0, p_load = 1, p_rst = 1;

    task automatic clear_meas();
        busy_cyc = 0; done_cnt = 0; cs_falls = 0; rises = 0; first_gap = -1;
        lo_min = 1000000; lo_max = 0; hi_min = 1000000; hi_max = 0; sdi_bad = 0;
        csh = -1; cs_bad = 0; ld2 = -1; ldw = -1; load_rises = 0; rss = -1; rstw = -1;
        word = '0;
    endtask

    always @(negedge clk) begin
        cyc++;
        if (busy_o && !p_busy) t_busy = cyc;
        if (busy_o) busy_cyc++;
        if (done_o) done_cnt++;
        if (!cs_n_o && p_cs) begin t_csf = cyc; cs_falls++; rises = 0; end
        if (sclk_o && !p_sclk) begin
            if (rises == 0) first_gap = cyc - t_csf;
            else begin
                if (cyc - t_sfall < lo_min) lo_min = cyc - t_sfall;
                if (cyc - t_sfall > lo_max) lo_max = cyc - t_sfall;
            end
            t_lrise = cyc; rises++;
            word = {word[14:0], sdi_o};
            if (!load_n_o) load_rises++;
        end
        if (!sclk_o && p_sclk) begin
            if (rises > 0) begin
                if (cyc - t_lrise < hi_min) hi_min = cyc - t_lrise;
                if (cyc - t_lrise > hi_max) hi_max = cyc - t_lrise;
            end
            t_sfall = cyc;
        end
        if (sclk_o && p_sclk && !cs_n_o && sdi_o != p_sdi) sdi_bad++;
        if (cs_n_o && !p_cs) begin csh = cyc - t_lrise; if (!sclk_o) cs_bad++; end
        if (!load_n_o && p_load) begin ld2 = cyc - t_lrise; t_lf = cyc; end
        if (load_n_o && !p_load) ldw = cyc - t_lf;
        if (!dac_rst_n_o && p_rst) begin rss = cyc - t_busy; t_rf = cyc; end
        if (dac_rst_n_o && !p_rst) rstw = cyc - t_rf;
        p_busy = busy_o; p_cs = cs_n_o; p_sclk = sclk_o; p_sdi = sdi_o;
        p_load = load_n_o; p_rst = dac_rst_n_o;
    end

    task automatic wait_done();
        for (int i = 0; i < 2000 && done_cnt == 0; i++) @(negedge clk);
        repeat (3) @(negedge clk);
        #1;
    endtask

    task automatic t_reset_state();
        #1;
        chk(cs_n_o && sclk_o && load_n_o && dac_rst_n_o, "R6", "idle pins", 
            {cs_n_o, sclk_o, load_n_o, dac_rst_n_o}, 15);
        chk(!busy_o && !done_o, "R6", "busy/done after reset", {busy_o, done_o}, 0);
    endtask

    task automatic t_write(input logic [1:0] ch, input logic [11:0] code);
        logic [15:0] exp_w;
        exp_w = {ch, 2'b00, code};
        clear_meas();
        @(negedge clk); chan_i = ch; code_i = code; start_i = 1'b1;
        @(negedge clk); start_i = 1'b0; chan_i = ~ch; code_i = ~code;
        wait_done();
        chk(word == exp_w, "R1", "word", int'(word), int'(exp_w));
        chk(word[15:14] == ch, "R1", "channel bits", int'(word[15:14]), int'(ch));
        chk(rises == 16, "R1", "rising edges", rises, 16);
        chk(lo_min == E_LOW && lo_max == E_LOW, "R2", "low phase", lo_max, E_LOW);
        chk(hi_min == E_HIGH && hi_max == E_HIGH, "R2", "high phase", hi_max, E_HIGH);
        chk(sdi_bad == 0, "R2", "data change while high", sdi_bad, 0);
        chk(first_gap == E_FIRST, "R3", "cs to first rise", first_gap, E_FIRST);
        chk(csh == E_TAIL && cs_bad == 0, "R4", "last rise to cs rise", csh, E_TAIL);
        chk(ld2 == E_TAIL, "R5", "last rise to load fall", ld2, E_TAIL);
        chk(ldw == E_LDW && load_rises == 0, "R5", "load width", ldw, E_LDW);
        chk(busy_cyc == E_BUSY, "R7", "busy length", busy_cyc, E_BUSY);
        chk(done_cnt == 1 && !busy_o, "R7", "done pulses", done_cnt, 1);
    endtask

    task automatic t_ignore_busy();
        clear_meas();
        @(negedge clk); chan_i = 2'd2; code_i = 12'h3C5; start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        repeat (40) @(negedge clk);
        chan_i = 2'd1; code_i = 12'h0F0; start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        wait_done();
        repeat (20) @(negedge clk);
        #1;
        chk(word == 16'h83C5, "R8", "word unaffected by busy start", int'(word), 'h83C5);
        chk(rises == 16 && cs_falls == 1, "R8", "single frame", cs_falls, 1);
        chk(!busy_o && done_cnt == 1, "R8", "no second transfer", done_cnt, 1);
    endtask

    task automatic t_dac_reset(input logic mid);
        clear_meas();
        @(negedge clk); rst_mid_i = mid; rst_req_i = 1'b1;
        @(negedge clk); rst_req_i = 1'b0; rst_mid_i = ~mid;
        wait_done();
        chk(rst_sel_o == mid, "R9", "reset select level", rst_sel_o, mid);
        chk(rss == E_RSS, "R9", "select to reset fall", rss, E_RSS);
        chk(rstw == E_RSTW, "R9", "reset low width", rstw, E_RSTW);
        chk(cs_falls == 0 && ld2 == -1, "R9", "serial pins quiet", cs_falls, 0);
        chk(done_cnt == 1 && !busy_o, "R7", "done after reset op", done_cnt, 1);
    endtask

    task automatic t_both();
        clear_meas();
        @(negedge clk); rst_mid_i = 1'b1; rst_req_i = 1'b1; start_i = 1'b1;
        chan_i = 2'd3; code_i = 12'hABC;
        @(negedge clk); rst_req_i = 1'b0; start_i = 1'b0;
        wait_done();
        repeat (10) @(negedge clk);
        #1;
        chk(rstw == E_RSTW, "R10", "reset performed", rstw, E_RSTW);
        chk(cs_falls == 0 && rises == 0, "R10", "start dropped", cs_falls, 0);
        chk(!busy_o && done_cnt == 1, "R10", "single operation", done_cnt, 1);
    endtask

    initial begin
        clear_meas();
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_write(2'd0, 12'hABC);
        t_write(2'd3, 12'hFFF);
        t_write(2'd2, 12'h000);
        t_write(2'd1, 12'h555);
        t_ignore_busy();
        t_dac_reset(1'b1);
        t_dac_reset(1'b0);
        t_both();
        t_write(2'd1, 12'h801);
        t_reset_state();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule